// File: doc/BRIEF.md
# Dual-Processor Mailbox Channel Controller

This block lets two processors signal each other through six independent one-way mailbox channels. Each processor (side 0 and side 1) owns one occupied flag per channel. The owner raises its flag to announce that a message is waiting; the peer lowers it to acknowledge that the message has been consumed. The payload itself lives elsewhere; the block carries only the occupancy handshake and the interrupts that go with it.

Each side reaches its own four-word register bank over a simple synchronous register port with its own select. Writes take effect on the clock edge that ends the write cycle. Reads are combinational from registered state. Each side has two level interrupt lines:
- The receive-occupied line reports that the peer has filled a channel.
- The transmit-free line reports that one of the side's own channels has been emptied.

Both lines are gated per channel by separate mask bits and per side by an enable bit.

Register words, indexed by the port address:
- Word 0 is control.
- Word 1 is the mask register.
- Word 2 is the write-one set/clear register.
- Word 3 is status.

Channels are numbered 1 to 6 to software and occupy bit positions 0 to 5 of each field.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, all twelve flags are clear and every mask bit is 1. Both enable bits of each side are 0 and all four interrupt outputs are low. Reads then return 0 for control, 0x00003F3F for mask, 0 for set/clear and 0 for status.
- R2: A write to word 2 with bit c (c in 0..5) set marks that side's own flag c occupied. From the next cycle it reads as bit c of the side's status and as bit 8+c of the peer's status.
- R3: A write to word 2 with bit 8+c set clears the peer's flag c. A side has no way to clear its own flags.
- R4: Word 2 is write-one: zero bits leave every flag unchanged, and reading word 2 returns 0.
- R5: When a side sets its flag c and the peer clears that same flag in the same cycle, the flag ends up set.
- R6: In word 0, bit 0 is the receive-occupied enable and bit 1 is the transmit-free enable. Both read back; every other bit of word 0 reads 0.
- R7: In word 1, bits 5:0 are the per-channel occupied masks and bits 13:8 are the per-channel free masks. A mask bit of 1 disables that channel's event, and the whole field reads back.
- R8: A side's receive-occupied output is high exactly when its enable is 1 and some peer flag c is set while the side's occupied mask bit c is 0.
- R9: A side's transmit-free output is high exactly when its enable is 1 and some own flag c is clear while the side's free mask bit c is 0.
- R10: Interrupt outputs are levels derived from registered state. They take their new value in the cycle right after the write that changes a flag, mask or enable, with no extra delay.
- R11: The channels are independent: setting or clearing one flag never alters any other flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_sel | input | 1 | Side 0 register access select |
| p0_we | input | 1 | Side 0 write enable (read when 0) |
| p0_addr | input | 2 | Side 0 word index |
| p0_wdata | input | 32 | Side 0 write data |
| p0_rdata | output | 32 | Side 0 read data, 0 when not selected |
| p0_irq_rx | output | 1 | Side 0 receive-occupied interrupt |
| p0_irq_tx | output | 1 | Side 0 transmit-free interrupt |
| p1_sel | input | 1 | Side 1 register access select |
| p1_we | input | 1 | Side 1 write enable (read when 0) |
| p1_addr | input | 2 | Side 1 word index |
| p1_wdata | input | 32 | Side 1 write data |
| p1_rdata | output | 32 | Side 1 read data, 0 when not selected |
| p1_irq_rx | output | 1 | Side 1 receive-occupied interrupt |
| p1_irq_tx | output | 1 | Side 1 transmit-free interrupt |

## Verification
The assertions rely on a few properties of the inputs:
- Select, write enable and address hold known values on every clock edge after reset.
- A write that is not selected does nothing.
- The two sides may write in the same cycle, including to the same channel.

The stimulus meets these conditions. It changes every input one time unit after a rising edge, drives both sides idle between accesses, and issues simultaneous set/clear cycles only through a dedicated dual-write step.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int unsigned MBX_SIDES      = 2;
    localparam int unsigned MBX_HI_LSB     = 8;
    localparam int unsigned MBX_CTL_RX_BIT = 0;
    localparam int unsigned MBX_CTL_TX_BIT = 1;
    localparam logic [1:0]  MBX_A_CTRL     = 2'd0;
    localparam logic [1:0]  MBX_A_MASK     = 2'd1;
    localparam logic [1:0]  MBX_A_SETCLR   = 2'd2;
    localparam logic [1:0]  MBX_A_STAT     = 2'd3;
endpackage

// File: rtl/mbx_side_port.sv
`timescale 1ns/1ps
module mbx_side_port
    import mbx_pkg::*;
#(
    parameter int unsigned NCH = 6,
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] own_flags,
    input  logic [NCH-1:0] peer_flags,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] set_req,
    output logic [NCH-1:0] clr_req,
    output logic           rx_en,
    output logic           tx_en,
    output logic [NCH-1:0] occ_mask,
    output logic [NCH-1:0] free_mask
);
    localparam logic [AW-1:0] A_CTRL   = AW'(MBX_A_CTRL);
    localparam logic [AW-1:0] A_MASK   = AW'(MBX_A_MASK);
    localparam logic [AW-1:0] A_SETCLR = AW'(MBX_A_SETCLR);
    localparam logic [AW-1:0] A_STAT   = AW'(MBX_A_STAT);

    typedef struct packed {
        logic           rx_en;
        logic           tx_en;
        logic [NCH-1:0] occ_m;
        logic [NCH-1:0] free_m;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_hit;
    logic unused_wbits;

    assign unused_wbits = ^wdata;
    assign wr_hit = sel & we;

    always_comb begin
        cfg_d   = cfg_q;
        set_req = '0;
        clr_req = '0;
        if (wr_hit) begin
            case (addr)
                A_CTRL: begin
                    cfg_d.rx_en = wdata[MBX_CTL_RX_BIT];
                    cfg_d.tx_en = wdata[MBX_CTL_TX_BIT];
                end
                A_MASK: begin
                    cfg_d.occ_m  = wdata[NCH-1:0];
                    cfg_d.free_m = wdata[MBX_HI_LSB +: NCH];
                end
                A_SETCLR: begin
                    set_req = wdata[NCH-1:0];
                    clr_req = wdata[MBX_HI_LSB +: NCH];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !we) begin
            case (addr)
                A_CTRL: begin
                    rdata[MBX_CTL_RX_BIT] = cfg_q.rx_en;
                    rdata[MBX_CTL_TX_BIT] = cfg_q.tx_en;
                end
                A_MASK: begin
                    rdata[NCH-1:0]            = cfg_q.occ_m;
                    rdata[MBX_HI_LSB +: NCH]  = cfg_q.free_m;
                end
                A_STAT: begin
                    rdata[NCH-1:0]            = own_flags;
                    rdata[MBX_HI_LSB +: NCH]  = peer_flags;
                end
                default: rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.rx_en  <= 1'b0;
            cfg_q.tx_en  <= 1'b0;
            cfg_q.occ_m  <= '1;
            cfg_q.free_m <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rx_en     = cfg_q.rx_en;
    assign tx_en     = cfg_q.tx_en;
    assign occ_mask  = cfg_q.occ_m;
    assign free_mask = cfg_q.free_m;

    a_r6_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr == A_CTRL) |=>
            (rx_en == $past(wdata[MBX_CTL_RX_BIT]) && tx_en == $past(wdata[MBX_CTL_TX_BIT])));

    a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr == A_MASK) |=>
            (occ_mask == $past(wdata[NCH-1:0]) && free_mask == $past(wdata[MBX_HI_LSB +: NCH])));

    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we && (addr == A_CTRL || addr == A_MASK)) |=>
            ($stable(occ_mask) && $stable(free_mask) && $stable(rx_en) && $stable(tx_en)));
endmodule

// File: rtl/mbx_flag_bank.sv
`timescale 1ns/1ps
module mbx_flag_bank
    import mbx_pkg::*;
#(
    parameter int unsigned NCH = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [MBX_SIDES-1:0][NCH-1:0]   set_req,
    input  logic [MBX_SIDES-1:0][NCH-1:0]   clr_req,
    output logic [MBX_SIDES-1:0][NCH-1:0]   flags
);
    typedef struct packed {
        logic [MBX_SIDES-1:0][NCH-1:0] flg;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int s = 0; s < MBX_SIDES; s++) begin
            bank_d.flg[s] = (bank_q.flg[s] & ~clr_req[MBX_SIDES-1-s]) | set_req[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign flags = bank_q.flg;

    for (genvar g = 0; g < MBX_SIDES; g++) begin : g_chk
        a_r2_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_req[g]) |=> ((flags[g] & $past(set_req[g])) == $past(set_req[g])));

        a_r3_peer_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (|(clr_req[MBX_SIDES-1-g] & ~set_req[g])) |=>
                ((flags[g] & $past(clr_req[MBX_SIDES-1-g] & ~set_req[g])) == '0));

        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (|(clr_req[MBX_SIDES-1-g] & set_req[g])) |=>
                ((flags[g] & $past(clr_req[MBX_SIDES-1-g] & set_req[g]))
                    == $past(clr_req[MBX_SIDES-1-g] & set_req[g])));

        a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (set_req[g] == '0 && clr_req[MBX_SIDES-1-g] == '0) |=> $stable(flags[g]));
    end
endmodule

// File: rtl/mbx_irq_gen.sv
`timescale 1ns/1ps
module mbx_irq_gen #(
    parameter int unsigned NCH = 6
) (
    input  logic           rx_en,
    input  logic           tx_en,
    input  logic [NCH-1:0] occ_mask,
    input  logic [NCH-1:0] free_mask,
    input  logic [NCH-1:0] own_flags,
    input  logic [NCH-1:0] peer_flags,
    output logic           irq_rx,
    output logic           irq_tx
);
    logic [NCH-1:0] rx_hits;
    logic [NCH-1:0] tx_hits;

    always_comb begin
        rx_hits = peer_flags & ~occ_mask;
        tx_hits = ~own_flags & ~free_mask;
        irq_rx  = rx_en & (|rx_hits);
        irq_tx  = tx_en & (|tx_hits);
    end
endmodule

// File: rtl/mbx_ctrl.sv
`timescale 1ns/1ps
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned NCH = 6,
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p0_sel,
    input  logic          p0_we,
    input  logic [AW-1:0] p0_addr,
    input  logic [DW-1:0] p0_wdata,
    output logic [DW-1:0] p0_rdata,
    output logic          p0_irq_rx,
    output logic          p0_irq_tx,
    input  logic          p1_sel,
    input  logic          p1_we,
    input  logic [AW-1:0] p1_addr,
    input  logic [DW-1:0] p1_wdata,
    output logic [DW-1:0] p1_rdata,
    output logic          p1_irq_rx,
    output logic          p1_irq_tx
);
    logic [MBX_SIDES-1:0]            sel, we, rx_en, tx_en, irq_rx, irq_tx;
    logic [MBX_SIDES-1:0][AW-1:0]    addr;
    logic [MBX_SIDES-1:0][DW-1:0]    wdata, rdata;
    logic [MBX_SIDES-1:0][NCH-1:0]   set_req, clr_req, flags, occ_mask, free_mask;

    assign sel   = {p1_sel, p0_sel};
    assign we    = {p1_we, p0_we};
    assign addr  = {p1_addr, p0_addr};
    assign wdata = {p1_wdata, p0_wdata};

    for (genvar g = 0; g < MBX_SIDES; g++) begin : g_side
        mbx_side_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (sel[g]),
            .we         (we[g]),
            .addr       (addr[g]),
            .wdata      (wdata[g]),
            .own_flags  (flags[g]),
            .peer_flags (flags[MBX_SIDES-1-g]),
            .rdata      (rdata[g]),
            .set_req    (set_req[g]),
            .clr_req    (clr_req[g]),
            .rx_en      (rx_en[g]),
            .tx_en      (tx_en[g]),
            .occ_mask   (occ_mask[g]),
            .free_mask  (free_mask[g])
        );

        mbx_irq_gen #(.NCH(NCH)) u_irq (
            .rx_en      (rx_en[g]),
            .tx_en      (tx_en[g]),
            .occ_mask   (occ_mask[g]),
            .free_mask  (free_mask[g]),
            .own_flags  (flags[g]),
            .peer_flags (flags[MBX_SIDES-1-g]),
            .irq_rx     (irq_rx[g]),
            .irq_tx     (irq_tx[g])
        );

        a_r8_rx_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!rx_en[g] || flags[MBX_SIDES-1-g] == '0) |-> !irq_rx[g]);

        a_r9_tx_quiet_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_en[g] || flags[g] == '1) |-> !irq_tx[g]);
    end

    mbx_flag_bank #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .flags   (flags)
    );

    assign p0_rdata  = rdata[0];
    assign p1_rdata  = rdata[1];
    assign p0_irq_rx = irq_rx[0];
    assign p0_irq_tx = irq_tx[0];
    assign p1_irq_rx = irq_rx[1];
    assign p1_irq_tx = irq_tx[1];
endmodule

// File: tb/test_mbx_ctrl.sv
`timescale 1ns/1ps
module test_mbx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p0_sel = 0, p0_we = 0, p1_sel = 0, p1_we = 0;
    logic [1:0]  p0_addr = 0, p1_addr = 0;
    logic [31:0] p0_wdata = 0, p1_wdata = 0;
    logic [31:0] p0_rdata, p1_rdata;
    logic        p0_irq_rx, p0_irq_tx, p1_irq_rx, p1_irq_tx;

    always #2 clk = ~clk;

    mbx_ctrl i_mbx_ctrl (
        .clk(clk), .rst_n(rst_n),
        .p0_sel(p0_sel), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
        .p0_rdata(p0_rdata), .p0_irq_rx(p0_irq_rx), .p0_irq_tx(p0_irq_tx),
        .p1_sel(p1_sel), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
        .p1_rdata(p1_rdata), .p1_irq_rx(p1_irq_rx), .p1_irq_tx(p1_irq_tx)
    );

    typedef struct {
        bit          is_irq;
        int          side;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [5:0] m_flag[2], m_occ[2], m_free[2];
    logic       m_rx[2], m_tx[2];

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            if (it.is_irq)
                act = (it.side == 0) ? {30'b0, p0_irq_rx, p0_irq_tx} : {30'b0, p1_irq_rx, p1_irq_tx};
            else
                act = (it.side == 0) ? p0_rdata : p1_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s side%0d actual=0x%08h expected=0x%08h", it.tag, it.side, act, it.exp);
            end
        end
    end

    task automatic bus(input logic s0, w0, input logic [1:0] a0, input logic [31:0] d0,
                       input logic s1, w1, input logic [1:0] a1, input logic [31:0] d1);
        logic [5:0] set[2], clr[2];
        p0_sel = s0; p0_we = w0; p0_addr = a0; p0_wdata = d0;
        p1_sel = s1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
        for (int s = 0; s < 2; s++) begin
            logic sw; logic [1:0] a; logic [31:0] d;
            sw = (s == 0) ? (s0 & w0) : (s1 & w1);
            a  = (s == 0) ? a0 : a1;
            d  = (s == 0) ? d0 : d1;
            set[s] = 0; clr[s] = 0;
            if (sw) begin
                if (a == 2'd0) begin m_rx[s] = d[0]; m_tx[s] = d[1]; end
                if (a == 2'd1) begin m_occ[s] = d[5:0]; m_free[s] = d[13:8]; end
                if (a == 2'd2) begin set[s] = d[5:0]; clr[s] = d[13:8]; end
            end
        end
        for (int s = 0; s < 2; s++)
            m_flag[s] = (m_flag[s] & ~clr[1-s]) | set[s];
        @(posedge clk); #1;
        p0_sel = 0; p0_we = 0; p1_sel = 0; p1_we = 0;
    endtask

    task automatic wr(input int s, input logic [1:0] a, input logic [31:0] d);
        if (s == 0) bus(1, 1, a, d, 0, 0, 0, 0);
        else        bus(0, 0, 0, 0, 1, 1, a, d);
    endtask

    task automatic rd(input int s, input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        if (s == 0) begin p0_sel = 1; p0_we = 0; p0_addr = a; end
        else        begin p1_sel = 1; p1_we = 0; p1_addr = a; end
        it.is_irq = 0; it.side = s; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
        p0_sel = 0; p1_sel = 0;
    endtask

    function automatic logic [31:0] stat_exp(input int s);
        return {18'b0, m_flag[1-s], 2'b0, m_flag[s]};
    endfunction

    task automatic chk_irq(input string tag);
        for (int s = 0; s < 2; s++) begin
            item_t it;
            logic rx, tx;
            rx = m_rx[s] & (|(m_flag[1-s] & ~m_occ[s]));
            tx = m_tx[s] & (|(~m_flag[s] & ~m_free[s]));
            it.is_irq = 1; it.side = s; it.exp = {30'b0, rx, tx}; it.tag = tag;
            q.push_back(it);
        end
        @(posedge clk); #1;
    endtask

    task automatic chk_stat(input string tag);
        rd(0, 2'd3, stat_exp(0), tag);
        rd(1, 2'd3, stat_exp(1), tag);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_flag[s] = 0; m_occ[s] = 6'h3F; m_free[s] = 6'h3F; m_rx[s] = 0; m_tx[s] = 0;
        end
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        @(posedge clk); #1;

        // R1 reset values
        for (int s = 0; s < 2; s++) begin
            rd(s, 2'd0, 32'h0, "R1 ctrl");
            rd(s, 2'd1, 32'h00003F3F, "R1 mask");
            rd(s, 2'd2, 32'h0, "R1 setclr");
            rd(s, 2'd3, 32'h0, "R1 status");
        end
        chk_irq("R1 irq");

        // R6 control bits
        wr(0, 2'd0, 32'hFFFF_FFFF);
        rd(0, 2'd0, 32'h3, "R6 ctrl both");
        wr(1, 2'd0, 32'h0000_0002);
        rd(1, 2'd0, 32'h2, "R6 ctrl tx only");
        chk_irq("R9 enabled but masked");

        // R7 masks, R9/R10 tx free with nothing occupied
        wr(0, 2'd1, 32'h0000_0000);
        rd(0, 2'd1, 32'h0, "R7 mask clear");
        chk_irq("R10 R9 tx-free after unmask");

        // R2 set channel 3 (bit 2) on side 1, R8 rx on side 0
        wr(1, 2'd2, 32'h0000_0004);
        chk_irq("R10 R8 rx after peer set");
        chk_stat("R2 set ch bit2");

        // R4 zero write does nothing
        wr(1, 2'd2, 32'h0);
        wr(0, 2'd2, 32'h0);
        chk_stat("R4 zero write");
        rd(1, 2'd2, 32'h0, "R4 setclr read");

        // R3 side 0 clears peer ch bit2; R3 side cannot clear own
        wr(1, 2'd2, 32'h0000_0400);
        chk_stat("R3 own clear ignored");
        wr(0, 2'd2, 32'h0000_0400);
        chk_stat("R3 peer clear");
        chk_irq("R8 rx drops");

        // R5 set wins on channel bit5
        bus(1, 1, 2'd2, 32'h0000_2000, 1, 1, 2'd2, 32'h0000_0020);
        chk_stat("R5 set wins");
        chk_irq("R8 rx from ch bit5");

        // R8 masked channel
        wr(0, 2'd1, 32'h0000_0020);
        chk_irq("R8 occ mask gates");
        wr(0, 2'd1, 32'h0);
        wr(0, 2'd0, 32'h2);
        chk_irq("R8 enable gates");

        // R9 full set, then free one; R11 independence
        wr(1, 2'd1, 32'h0);
        wr(1, 2'd2, 32'h0000_003F);
        chk_irq("R9 all occupied");
        wr(0, 2'd2, 32'h0000_0100);
        chk_stat("R11 single clear");
        chk_irq("R9 tx-free after peer clear");
        wr(1, 2'd1, 32'h0000_0100);
        rd(1, 2'd1, 32'h0000_0100, "R7 free mask read");
        chk_irq("R9 free mask gates");

        // R2 side 0 sets several, R11
        wr(0, 2'd2, 32'h0000_0009);
        chk_stat("R11 R2 side0 multi set");
        wr(0, 2'd0, 32'h3);
        chk_irq("R8 R9 final");

        repeat (2) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule